// File: doc/BRIEF.md
# Paired-Single Crossed Swap Unit

This unit executes one floating-point register instruction that takes two 82-bit register values, each carrying two packed 32-bit single-precision numbers in its 64-bit significand, and builds a destination value from crossed halves. The upper word of the result comes from the low word of the second source, and the lower word comes from the high word of the first source. Two variants invert the top bit of one of the two result words, which negates that packed single. A written result always carries the fixed integer exponent 0x1003E and a positive sign.

The unit sits in an execution pipeline. The issue stage presents a valid strobe, the qualifying predicate, a form code, the two operand values with their not-a-thing tags, and per-register disable indications. One cycle later the unit presents a registered result: a write enable, the 82-bit data with its tag, and two fault flags. A false predicate turns the instruction into a no-op. A poisoned source produces the not-a-thing encoding instead of the swap. A fault suppresses the write.

Register layout: bit 81 is the sign, bits 80:64 are the exponent, and bits 63:0 are the significand. "First source" means `src_a` and "second source" means `src_b`.

Top module: `pswap_unit`

## Requirements
- R1: `out_valid` is 1 in the cycle after a cycle in which `in_valid` was 1, and 0 after a cycle in which it was 0. Reset clears `out_valid`, `wr_en`, `fault_dis` and `fault_ill`.
- R2: When `pred` is 0, an accepted instruction gives `wr_en`=0, `fault_dis`=0 and `fault_ill`=0.
- R3: For form code 0 (plain swap), and for form code 3, which behaves the same way, result bits 63:32 equal `src_b` bits 31:0 and result bits 31:0 equal `src_a` bits 63:32.
- R4: For form code 1 (negate upper word), result bit 63 is the inverse of `src_b` bit 31, result bits 62:32 equal `src_b` bits 30:0, and the low word is as in R3.
- R5: For form code 2 (negate lower word), result bit 31 is the inverse of `src_a` bit 63, result bits 30:0 equal `src_a` bits 62:32, and the high word is as in R3.
- R6: A written result whose sources are both untagged has exponent bits 80:64 equal to 0x1003E, sign bit 81 equal to 0, and `wr_nat`=0. The input exponents and signs have no effect.
- R7: If `src_a_nat` or `src_b_nat` is 1, the written data is sign 0, exponent 0x1FFFE and significand 0, and `wr_nat` is 1.
- R8: With `pred`=1 and `dst_bad`=0, if any of `dst_dis`, `src_a_dis` or `src_b_dis` is 1, then `fault_dis` is 1 and `wr_en` is 0.
- R9: With `pred`=1 and `dst_bad`=1, `fault_ill` is 1, `fault_dis` is 0 and `wr_en` is 0. This fault takes priority over the disable fault.
- R10: `wr_en`, `fault_dis` and `fault_ill` are 0 in any cycle that does not follow an accepted instruction. When `pred`=1 and there is no fault, `wr_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction presented this cycle |
| pred | input | 1 | Qualifying predicate |
| form | input | 2 | 0 swap, 1 negate upper word, 2 negate lower word, 3 swap |
| src_a | input | 82 | First source register value |
| src_a_nat | input | 1 | First source holds not-a-thing |
| src_b | input | 82 | Second source register value |
| src_b_nat | input | 1 | Second source holds not-a-thing |
| dst_dis | input | 1 | Destination register disabled |
| src_a_dis | input | 1 | First source register disabled |
| src_b_dis | input | 1 | Second source register disabled |
| dst_bad | input | 1 | Destination is not a legal target |
| out_valid | output | 1 | Registered result present |
| wr_en | output | 1 | Destination write enable |
| wr_data | output | 82 | Destination value |
| wr_nat | output | 1 | Destination not-a-thing tag |
| fault_dis | output | 1 | Disabled-register fault |
| fault_ill | output | 1 | Illegal-operation fault |

## Verification
Every output is due exactly one clock edge after the edge that accepts the instruction, because a single register stage sits between the ports. The bench drives each instruction at a falling edge and then waits for the next rising edge. It samples all outputs at the following falling edge, so the registered values have settled, and it compares them with a model built from the requirement bit layouts. It inserts idle cycles and samples one falling edge after each of them, which confirms that the strobes drop back to zero.

// File: rtl/pswap_pkg.sv
package pswap_pkg;

    typedef enum logic [1:0] {
        FORM_SWAP     = 2'd0,
        FORM_NEG_HI   = 2'd1,
        FORM_NEG_LO   = 2'd2,
        FORM_SWAP_ALT = 2'd3
    } form_e;

    localparam int DEF_HALF_W = 32;
    localparam int DEF_EXP_W  = 17;

endpackage

// File: rtl/pswap_halves.sv
module pswap_halves
    import pswap_pkg::*;
#(
    parameter int HALF_W = DEF_HALF_W,
    localparam int SIG_W = 2 * HALF_W
) (
    input  form_e              form,
    input  logic [SIG_W-1:0]   sig_a,
    input  logic [SIG_W-1:0]   sig_b,
    output logic [SIG_W-1:0]   sig_y
);

    // word 1 (upper) <- low word of sig_b ; word 0 (lower) <- high word of sig_a
    for (genvar h = 0; h < 2; h++) begin : g_word
        logic [HALF_W-1:0] pick;
        logic              flip;
        if (h == 1) begin : g_upper
            assign pick = sig_b[HALF_W-1:0];
            assign flip = (form == FORM_NEG_HI);
        end else begin : g_lower
            assign pick = sig_a[SIG_W-1:HALF_W];
            assign flip = (form == FORM_NEG_LO);
        end
        assign sig_y[h*HALF_W +: HALF_W] = {pick[HALF_W-1] ^ flip, pick[HALF_W-2:0]};
    end

endmodule

// File: rtl/pswap_result.sv
module pswap_result #(
    parameter int              HALF_W  = 32,
    parameter int              EXP_W   = 17,
    parameter logic [EXP_W-1:0] INT_EXP = 17'h1003E,
    parameter logic [EXP_W-1:0] NAT_EXP = 17'h1FFFE,
    localparam int SIG_W = 2 * HALF_W,
    localparam int REG_W = 1 + EXP_W + SIG_W
) (
    input  logic             nat_a,
    input  logic             nat_b,
    input  logic [SIG_W-1:0] sig,
    output logic [REG_W-1:0] data,
    output logic             nat
);

    always_comb begin
        nat = nat_a | nat_b;
        if (nat) begin
            data = {1'b0, NAT_EXP, {SIG_W{1'b0}}};
        end else begin
            data = {1'b0, INT_EXP, sig};
        end
    end

endmodule

// File: rtl/pswap_fault.sv
module pswap_fault (
    input  logic       pred,
    input  logic       dst_bad,
    input  logic [2:0] dis_vec,
    output logic       f_ill,
    output logic       f_dis,
    output logic       wr_ok
);

    // target legality is checked before register disables
    always_comb begin
        f_ill = pred & dst_bad;
        f_dis = pred & ~dst_bad & (|dis_vec);
        wr_ok = pred & ~f_ill & ~f_dis;
    end

endmodule

// File: rtl/pswap_unit.sv
module pswap_unit
    import pswap_pkg::*;
#(
    parameter int               HALF_W  = DEF_HALF_W,
    parameter int               EXP_W   = DEF_EXP_W,
    parameter logic [EXP_W-1:0] INT_EXP = 17'h1003E,
    parameter logic [EXP_W-1:0] NAT_EXP = 17'h1FFFE,
    localparam int SIG_W = 2 * HALF_W,
    localparam int REG_W = 1 + EXP_W + SIG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             pred,
    input  logic [1:0]       form,
    input  logic [REG_W-1:0] src_a,
    input  logic             src_a_nat,
    input  logic [REG_W-1:0] src_b,
    input  logic             src_b_nat,
    input  logic             dst_dis,
    input  logic             src_a_dis,
    input  logic             src_b_dis,
    input  logic             dst_bad,
    output logic             out_valid,
    output logic             wr_en,
    output logic [REG_W-1:0] wr_data,
    output logic             wr_nat,
    output logic             fault_dis,
    output logic             fault_ill
);

    typedef struct packed {
        logic             valid;
        logic             wr_en;
        logic             f_dis;
        logic             f_ill;
        logic             nat;
        logic [REG_W-1:0] data;
    } stage_t;

    stage_t st_d, st_q;

    logic [SIG_W-1:0] sig_sw;
    logic [REG_W-1:0] res_data;
    logic             res_nat;
    logic             f_ill, f_dis, wr_ok;

    pswap_halves #(.HALF_W(HALF_W)) u_halves (
        .form  (form_e'(form)),
        .sig_a (src_a[SIG_W-1:0]),
        .sig_b (src_b[SIG_W-1:0]),
        .sig_y (sig_sw)
    );

    pswap_result #(
        .HALF_W (HALF_W),
        .EXP_W  (EXP_W),
        .INT_EXP(INT_EXP),
        .NAT_EXP(NAT_EXP)
    ) u_result (
        .nat_a (src_a_nat),
        .nat_b (src_b_nat),
        .sig   (sig_sw),
        .data  (res_data),
        .nat   (res_nat)
    );

    pswap_fault u_fault (
        .pred    (pred),
        .dst_bad (dst_bad),
        .dis_vec ({dst_dis, src_a_dis, src_b_dis}),
        .f_ill   (f_ill),
        .f_dis   (f_dis),
        .wr_ok   (wr_ok)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.wr_en = in_valid & wr_ok;
        st_d.f_dis = in_valid & f_dis;
        st_d.f_ill = in_valid & f_ill;
        if (in_valid) begin
            st_d.nat  = res_nat;
            st_d.data = res_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign wr_en     = st_q.wr_en;
    assign fault_dis = st_q.f_dis;
    assign fault_ill = st_q.f_ill;
    assign wr_nat    = st_q.nat;
    assign wr_data   = st_q.data;

endmodule

// File: rtl/pswap_unit_chk.sv
module pswap_unit_chk #(
    parameter int               HALF_W  = 32,
    parameter int               EXP_W   = 17,
    parameter logic [EXP_W-1:0] INT_EXP = 17'h1003E,
    localparam int SIG_W = 2 * HALF_W,
    localparam int REG_W = 1 + EXP_W + SIG_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             pred,
    input logic             src_a_nat,
    input logic             src_b_nat,
    input logic             dst_dis,
    input logic             src_a_dis,
    input logic             src_b_dis,
    input logic             dst_bad,
    input logic             out_valid,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic             wr_nat,
    input logic             fault_dis,
    input logic             fault_ill
);

    p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_pred_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !pred) |=> (!wr_en && !fault_dis && !fault_ill));

    p_int_exp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_nat) |-> (wr_data[REG_W-2:SIG_W] == INT_EXP && !wr_data[REG_W-1]));

    p_nat_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred && !dst_bad && !dst_dis && !src_a_dis && !src_b_dis
         && (src_a_nat || src_b_nat)) |=> (wr_en && wr_nat));

    p_fault_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (fault_dis || fault_ill)));

    p_fault_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_dis && fault_ill));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || fault_dis || fault_ill) |-> out_valid);

endmodule

bind pswap_unit pswap_unit_chk #(
    .HALF_W (HALF_W),
    .EXP_W  (EXP_W),
    .INT_EXP(INT_EXP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .pred      (pred),
    .src_a_nat (src_a_nat),
    .src_b_nat (src_b_nat),
    .dst_dis   (dst_dis),
    .src_a_dis (src_a_dis),
    .src_b_dis (src_b_dis),
    .dst_bad   (dst_bad),
    .out_valid (out_valid),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .wr_nat    (wr_nat),
    .fault_dis (fault_dis),
    .fault_ill (fault_ill)
);

// File: tb/sim_pswap_unit.sv
module sim_pswap_unit;

    localparam int W = 82;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         pred = 1'b0;
    logic [1:0]   form = 2'd0;
    logic [W-1:0] src_a = '0;
    logic [W-1:0] src_b = '0;
    logic         src_a_nat = 1'b0, src_b_nat = 1'b0;
    logic         dst_dis = 1'b0, src_a_dis = 1'b0, src_b_dis = 1'b0, dst_bad = 1'b0;
    logic         out_valid, wr_en, wr_nat, fault_dis, fault_ill;
    logic [W-1:0] wr_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pswap_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pred(pred), .form(form),
        .src_a(src_a), .src_a_nat(src_a_nat), .src_b(src_b), .src_b_nat(src_b_nat),
        .dst_dis(dst_dis), .src_a_dis(src_a_dis), .src_b_dis(src_b_dis), .dst_bad(dst_bad),
        .out_valid(out_valid), .wr_en(wr_en), .wr_data(wr_data), .wr_nat(wr_nat),
        .fault_dis(fault_dis), .fault_ill(fault_ill)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pattern(input int p, input int which);
        logic [31:0] hi, lo;
        hi = 32'(p * 32'h9E3779B9 + which * 32'h1234567);
        lo = 32'(p * 32'h7F4A7C15 ^ (which * 32'h0F0F0F0F));
        if (p[0]) hi[31] = ~hi[31];
        if (p[1]) lo[31] = ~lo[31];
        return {p[2], 17'(p * 17'h0ABC), hi, lo};
    endfunction

    task automatic run_one(input int p, input int fm, input int ctl);
        bit e_ill, e_dis, e_wr, e_nat, anydis;
        logic [31:0] e_hi, e_lo;
        logic [W-1:0] e_data;
        string rq;
        @(negedge clk);
        in_valid = 1'b1;
        form = 2'(fm);
        pred = ctl[0]; src_a_nat = ctl[1]; src_b_nat = ctl[2];
        dst_dis = ctl[3]; src_a_dis = ctl[4]; src_b_dis = ctl[5]; dst_bad = ctl[6];
        src_a = pattern(p, 1);
        src_b = pattern(p + 7, 2);
        anydis = ctl[3] | ctl[4] | ctl[5];
        e_ill = ctl[0] & ctl[6];
        e_dis = ctl[0] & !ctl[6] & anydis;
        e_wr  = ctl[0] & !e_ill & !e_dis;
        e_nat = ctl[1] | ctl[2];
        e_hi = src_b[31:0];
        e_lo = src_a[63:32];
        if (fm == 1) e_hi[31] = ~src_b[31];
        if (fm == 2) e_lo[31] = ~src_a[63];
        if (e_nat) e_data = {1'b0, 17'h1FFFE, 64'h0};
        else       e_data = {1'b0, 17'h1003E, e_hi, e_lo};
        rq = (fm == 1) ? "R4" : (fm == 2) ? "R5" : "R3";
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R1 out_valid", W'(out_valid), W'(1));
        if (!ctl[0])
            check(!wr_en && !fault_dis && !fault_ill, "R2 predicate off",
                  W'({wr_en, fault_dis, fault_ill}), W'(0));
        check(fault_ill == e_ill, "R9 fault_ill", W'(fault_ill), W'(e_ill));
        check(fault_dis == e_dis, "R8 fault_dis", W'(fault_dis), W'(e_dis));
        check(wr_en == e_wr, "R10 wr_en", W'(wr_en), W'(e_wr));
        if (e_wr) begin
            check(wr_nat == e_nat, e_nat ? "R7 tag" : "R6 tag", W'(wr_nat), W'(e_nat));
            if (e_nat)
                check(wr_data == e_data, "R7 data", wr_data, e_data);
            else begin
                check(wr_data[63:0] == e_data[63:0], rq, wr_data, e_data);
                check(wr_data[81:64] == e_data[81:64], "R6 exp/sign", wr_data, e_data);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid && !wr_en && !fault_dis && !fault_ill, "R1 reset",
              W'({out_valid, wr_en, fault_dis, fault_ill}), W'(0));
        rst_n = 1'b1;
        for (int p = 0; p < 6; p++) begin
            for (int fm = 0; fm < 4; fm++) begin
                for (int ctl = 0; ctl < 128; ctl++) begin
                    run_one(p, fm, ctl);
                end
                @(negedge clk);
                check(!out_valid && !wr_en && !fault_dis && !fault_ill, "R10 idle",
                      W'({out_valid, wr_en, fault_dis, fault_ill}), W'(0));
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule